// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between a clocked host and an external asynchronous static RAM of 262,144 words by 16 bits. The host issues one word per request through a request/ready handshake, carrying an 18-bit word address, 16 bits of write data and a two-bit active-high lane mask. The controller turns each accepted request into the memory's active-low strobes (chip select, write strobe, output enable and two byte-lane selects), all of them registered, and returns read data with a one-cycle valid pulse.

Every interval is counted in whole clock cycles. The cycle counts come from the memory's nanosecond limits and the clock period (`CLK_NS`), always rounded up. With the default 10 ns clock, the write strobe stays low for 5 cycles. A write access holds chip select for 7 cycles. A read access holds chip select and output enable for 7 cycles and is followed by 2 turnaround cycles. During those cycles the memory's output drivers switch off, before any later access can drive the data bus. Between two accesses the memory always spends at least one cycle in standby: chip select and both lane selects are high.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset, and in every cycle where `host_ready` is 1, `mem_ce_n`, `mem_we_n`, `mem_oe_n`, `mem_lb_n` and `mem_ub_n` are 1 and `mem_dq_oe` is 0. `host_ready` is 1 and `host_rvalid` is 0 after reset.
- R2: Host mask bit 0 selects lane data[7:0] and drives `mem_lb_n` low. Bit 1 selects data[15:8] and drives `mem_ub_n` low. Both lane selects keep their value for the whole access.
- R3: In a write accepted at edge k, `mem_we_n` is 0 for exactly W_LOW cycles (5 at 10 ns), from edge k to edge k+W_LOW. `mem_dq_oe` is 1 exactly while `mem_we_n` is 0, and `mem_dq_out` then carries the accepted write data. `mem_oe_n` stays 1 throughout.
- R4: `mem_ce_n` is 0 for exactly WC cycles (7 at 10 ns) in a write and for RC cycles (7) in a read. `host_ready` returns to 1 after edge k+WC for a write.
- R5: During a read, `mem_oe_n` is 0 together with `mem_ce_n`, `mem_we_n` stays 1 and `mem_dq_oe` stays 0.
- R6: Read data is sampled at the last edge of the read access, k+RC. In the following cycle `host_rvalid` is 1 for exactly one cycle. `host_rdata` then holds the selected lanes of the memory word and zero in the unselected lanes.
- R7: After a read, `host_ready` stays 0 for TURN further cycles (2 at 10 ns), so it returns to 1 after edge k+RC+TURN.
- R8: A request with mask 00 does not touch the memory: strobes stay high and `host_ready` stays 1. For a read, the next cycle shows `host_rvalid` = 1 with `host_rdata` = 0.
- R9: A request raised while `host_ready` is 0 is ignored. The access in progress keeps its address, lanes and strobe pattern, and memory content is unchanged.
- R10: `mem_addr` carries all 18 bits of the accepted host address and holds them while `mem_ce_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_req | input | 1 | Request valid |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 18 | Word address |
| host_wdata | input | 16 | Write data |
| host_be | input | 2 | Active-high lane mask (bit 0 low byte) |
| host_ready | output | 1 | Controller can accept a request |
| host_rdata | output | 16 | Read data |
| host_rvalid | output | 1 | One-cycle read-data strobe |
| mem_addr | output | 18 | Memory address |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lb_n | output | 1 | Lower lane select, active low |
| mem_ub_n | output | 1 | Upper lane select, active low |
| mem_dq_out | output | 16 | Data toward the memory |
| mem_dq_oe | output | 1 | Enable of the data driver |
| mem_dq_in | input | 16 | Data from the memory |

## Verification
The assertions assume that the host leaves `host_req` low, or raises it only in cycles whose effect is defined (accepted when ready, ignored otherwise). They also assume that `mem_dq_in` holds a settled word at the sampling edge of a read. The bench drives all host inputs on the falling clock edge, so every request is seen whole at one rising edge. Its memory model presents valid data only after the access has lasted the full read time, and puts distinct filler patterns on unselected lanes and on early samples. A read sampled too early, or one that fails to zero an unused lane, therefore shows up as a wrong value.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_WRITE = 2'd1,
      ST_READ  = 2'd2,
      ST_TURN  = 2'd3
   } ctl_state_t;

   // nanoseconds to whole clock cycles, rounded up
   function automatic int ns_to_cyc(input int ns, input int clk_ns);
      return (ns + clk_ns - 1) / clk_ns;
   endfunction

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] count,
   output logic             at_zero
);

   always_ff @(posedge clk) begin
      if (rst)
         count <= '0;
      else if (load)
         count <= load_val;
      else if (count != '0)
         count <= count - 1'b1;
   end

   assign at_zero = (count == '0);

   // R4
   timer_floor_chk: assert property (@(posedge clk) disable iff (rst)
      (!load && at_zero) |=> at_zero);

endmodule

// File: rtl/sram_lane_mask.sv
module sram_lane_mask #(
   parameter int LANES  = 2,
   parameter int LANE_W = 8
) (
   input  logic [LANES-1:0]        lane_n,
   input  logic [LANES*LANE_W-1:0] raw,
   output logic [LANES*LANE_W-1:0] masked
);

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign masked[l*LANE_W +: LANE_W] = lane_n[l] ? '0 : raw[l*LANE_W +: LANE_W];
   end

endmodule

// File: rtl/sram_access_seq.sv
module sram_access_seq
   import sram_lane_pkg::*;
#(
   parameter int LANES     = 2,
   parameter int W_LOW_CYC = 5,
   parameter int WC_CYC    = 7,
   parameter int RC_CYC    = 7,
   parameter int TURN_CYC  = 2,
   parameter int CNT_W     = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             req,
   input  logic             is_write,
   input  logic [LANES-1:0] host_be,
   output logic             ready,
   output logic             accept,
   output logic             zero_rd,
   output logic             capture,
   output logic             ce_n,
   output logic             we_n,
   output logic             oe_n,
   output logic [LANES-1:0] lane_n,
   output logic             dq_oe
);

   localparam logic [CNT_W-1:0] WC_LD   = CNT_W'(WC_CYC - 1);
   localparam logic [CNT_W-1:0] RC_LD   = CNT_W'(RC_CYC - 1);
   localparam logic [CNT_W-1:0] TURN_LD = CNT_W'((TURN_CYC > 0) ? TURN_CYC - 1 : 0);
   localparam logic [CNT_W-1:0] WE_RISE = CNT_W'(WC_CYC - W_LOW_CYC);

   ctl_state_t       state;
   ctl_state_t       after_read;
   logic             turn_used;
   logic [CNT_W-1:0] cnt;
   logic             cnt_zero;
   logic             tmr_load;
   logic [CNT_W-1:0] tmr_val;

   if (TURN_CYC > 0) begin : g_turn
      assign after_read = ST_TURN;
      assign turn_used  = 1'b1;
   end else begin : g_no_turn
      assign after_read = ST_IDLE;
      assign turn_used  = 1'b0;
   end

   assign ready   = (state == ST_IDLE);
   assign accept  = ready && req && (|host_be);
   assign zero_rd = ready && req && !(|host_be) && !is_write;
   assign capture = (state == ST_READ) && cnt_zero;

   assign tmr_load = accept || (capture && turn_used);
   assign tmr_val  = accept ? (is_write ? WC_LD : RC_LD) : TURN_LD;

   sram_cycle_timer #(.CNT_W(CNT_W)) i_timer (
      .clk      (clk),
      .rst      (rst),
      .load     (tmr_load),
      .load_val (tmr_val),
      .count    (cnt),
      .at_zero  (cnt_zero)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state  <= ST_IDLE;
         ce_n   <= 1'b1;
         we_n   <= 1'b1;
         oe_n   <= 1'b1;
         lane_n <= '1;
         dq_oe  <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (accept) begin
                  ce_n   <= 1'b0;
                  lane_n <= ~host_be;
                  if (is_write) begin
                     we_n  <= 1'b0;
                     dq_oe <= 1'b1;
                     state <= ST_WRITE;
                  end else begin
                     oe_n  <= 1'b0;
                     state <= ST_READ;
                  end
               end
            end
            ST_WRITE: begin
               if (cnt == WE_RISE) begin
                  we_n  <= 1'b1;
                  dq_oe <= 1'b0;
               end
               if (cnt_zero) begin
                  ce_n   <= 1'b1;
                  lane_n <= '1;
                  we_n   <= 1'b1;
                  dq_oe  <= 1'b0;
                  state  <= ST_IDLE;
               end
            end
            ST_READ: begin
               if (cnt_zero) begin
                  ce_n   <= 1'b1;
                  oe_n   <= 1'b1;
                  lane_n <= '1;
                  state  <= after_read;
               end
            end
            ST_TURN: begin
               if (cnt_zero)
                  state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R3
   drive_only_in_write_chk: assert property (@(posedge clk) disable iff (rst)
      dq_oe |-> (!we_n && !ce_n));

   // R3
   we_blocks_oe_chk: assert property (@(posedge clk) disable iff (rst)
      !we_n |-> oe_n);

   // R1
   idle_standby_chk: assert property (@(posedge clk) disable iff (rst)
      ready |-> (ce_n && we_n && oe_n && (&lane_n) && !dq_oe));

   // R8
   empty_mask_chk: assert property (@(posedge clk) disable iff (rst)
      (ready && req && !(|host_be)) |=> (ready && ce_n));

   // R2
   lanes_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!ce_n && $past(!ce_n)) |-> $stable(lane_n));

   // R5
   read_strobe_chk: assert property (@(posedge clk) disable iff (rst)
      !oe_n |-> (!ce_n && we_n && !dq_oe));

   if (W_LOW_CYC > 1) begin : g_we_min
      // R3
      we_min_width_chk: assert property (@(posedge clk) disable iff (rst)
         $fell(we_n) |=> !we_n);
   end

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
   import sram_lane_pkg::*;
#(
   parameter int CLK_NS  = 10,
   parameter int ADDR_W  = 18,
   parameter int DATA_W  = 16,
   parameter int T_WP_NS = 40,
   parameter int T_DW_NS = 40,
   parameter int T_AW_NS = 50,
   parameter int T_RC_NS = 70,
   parameter int T_AA_NS = 70,
   parameter int T_OE_NS = 25,
   parameter int T_HZ_NS = 20
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              host_req,
   input  logic              host_write,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic [1:0]        host_be,
   output logic              host_ready,
   output logic [DATA_W-1:0] host_rdata,
   output logic              host_rvalid,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_ce_n,
   output logic              mem_we_n,
   output logic              mem_oe_n,
   output logic              mem_lb_n,
   output logic              mem_ub_n,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_in
);

   localparam int LANES     = 2;
   localparam int LANE_W    = DATA_W / LANES;
   localparam int W_LOW_CYC = max_of(ns_to_cyc(max_of(T_WP_NS, T_DW_NS), CLK_NS),
                                     ns_to_cyc(T_AW_NS, CLK_NS));
   localparam int RC_CYC    = max_of(max_of(ns_to_cyc(T_RC_NS, CLK_NS),
                                            ns_to_cyc(T_AA_NS, CLK_NS)),
                                     ns_to_cyc(T_OE_NS, CLK_NS));
   localparam int WC_CYC    = max_of(W_LOW_CYC, ns_to_cyc(T_RC_NS, CLK_NS));
   localparam int TURN_CYC  = ns_to_cyc(T_HZ_NS, CLK_NS);
   localparam int MAX_CYC   = max_of(max_of(WC_CYC, RC_CYC), TURN_CYC);
   localparam int CNT_W     = $clog2(MAX_CYC + 1);

   if (CLK_NS < 1) begin : g_bad_clk
      $error("CLK_NS must be positive");
   end
   if ((DATA_W % LANES) != 0 || DATA_W < 2) begin : g_bad_width
      $error("DATA_W must split into two equal lanes");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("ADDR_W must be positive");
   end
   if (W_LOW_CYC < 1 || RC_CYC < 1) begin : g_bad_timing
      $error("access timing must be at least one cycle");
   end

   logic             accept;
   logic             zero_rd;
   logic             capture;
   logic [LANES-1:0] lane_n;
   logic [DATA_W-1:0] lane_data;

   sram_access_seq #(
      .LANES     (LANES),
      .W_LOW_CYC (W_LOW_CYC),
      .WC_CYC    (WC_CYC),
      .RC_CYC    (RC_CYC),
      .TURN_CYC  (TURN_CYC),
      .CNT_W     (CNT_W)
   ) i_seq (
      .clk      (clk),
      .rst      (rst),
      .req      (host_req),
      .is_write (host_write),
      .host_be  (host_be),
      .ready    (host_ready),
      .accept   (accept),
      .zero_rd  (zero_rd),
      .capture  (capture),
      .ce_n     (mem_ce_n),
      .we_n     (mem_we_n),
      .oe_n     (mem_oe_n),
      .lane_n   (lane_n),
      .dq_oe    (mem_dq_oe)
   );

   assign mem_lb_n = lane_n[0];
   assign mem_ub_n = lane_n[1];

   sram_lane_mask #(.LANES(LANES), .LANE_W(LANE_W)) i_mask (
      .lane_n (lane_n),
      .raw    (mem_dq_in),
      .masked (lane_data)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         mem_addr   <= '0;
         mem_dq_out <= '0;
      end else if (accept) begin
         mem_addr   <= host_addr;
         mem_dq_out <= host_wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         host_rdata  <= '0;
         host_rvalid <= 1'b0;
      end else begin
         host_rvalid <= capture || zero_rd;
         if (capture)
            host_rdata <= lane_data;
         else if (zero_rd)
            host_rdata <= '0;
      end
   end

   // R6
   rvalid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      host_rvalid |=> !host_rvalid);

   // R10
   addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

   // R9
   busy_no_accept_chk: assert property (@(posedge clk) disable iff (rst)
      (!host_ready && !mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_dq_out));

endmodule

// File: tb/test_sram_lane_ctrl.sv
module test_sram_lane_ctrl;

   localparam int CLK  = 10;
   localparam int WLOW = ((50 + CLK - 1) / CLK > (40 + CLK - 1) / CLK) ?
                         (50 + CLK - 1) / CLK : (40 + CLK - 1) / CLK;
   localparam int RC   = (70 + CLK - 1) / CLK;
   localparam int WC   = (RC > WLOW) ? RC : WLOW;
   localparam int TURN = (20 + CLK - 1) / CLK;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        host_req = 1'b0;
   logic        host_write = 1'b0;
   logic [17:0] host_addr = '0;
   logic [15:0] host_wdata = '0;
   logic [1:0]  host_be = '0;
   logic        host_ready;
   logic [15:0] host_rdata;
   logic        host_rvalid;
   logic [17:0] mem_addr;
   logic        mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n;
   logic [15:0] mem_dq_out;
   logic        mem_dq_oe;
   logic [15:0] mem_dq_in;

   int total = 0;
   int bad   = 0;

   logic [15:0] model [64];
   logic [15:0] shadow [64];
   int          age = 0;

   always #5 clk = ~clk;

   sram_lane_ctrl i_sram_lane_ctrl (
      .clk(clk), .rst(rst), .host_req(host_req), .host_write(host_write),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_be(host_be),
      .host_ready(host_ready), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
      .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
      .mem_oe_n(mem_oe_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
      .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
   );

   // memory model: word valid only after the full access time
   always @(posedge clk) age <= (!mem_ce_n && !mem_oe_n) ? age + 1 : 0;

   always_comb begin
      if (!mem_ce_n && !mem_oe_n && mem_we_n && age >= RC - 1)
         mem_dq_in = {mem_ub_n ? 8'hA5 : model[mem_addr[5:0]][15:8],
                      mem_lb_n ? 8'h5A : model[mem_addr[5:0]][7:0]};
      else
         mem_dq_in = 16'hBEEF;
   end

   always @(negedge clk) begin
      if (!rst && !mem_ce_n && !mem_we_n && mem_dq_oe) begin
         if (!mem_lb_n) model[mem_addr[5:0]][7:0]  = mem_dq_out[7:0];
         if (!mem_ub_n) model[mem_addr[5:0]][15:8] = mem_dq_out[15:8];
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   task automatic access(input bit wr, input logic [17:0] a, input logic [15:0] d,
                         input logic [1:0] be, input bit stray);
      int lane_err = 0, we_err = 0, ce_err = 0, rd_err = 0, addr_err = 0, busy_err = 0;
      logic [15:0] exp;
      int n;
      while (!host_ready) @(negedge clk);
      host_req = 1'b1; host_write = wr; host_addr = a; host_wdata = d; host_be = be;
      @(negedge clk);
      host_req = 1'b0;
      if (be == 2'b00) begin
         // R8: nothing reaches the memory
         chk(mem_ce_n && host_ready && mem_we_n, "R8 strobes",
             {mem_ce_n, host_ready, mem_we_n}, 3'b111);
         if (!wr) begin
            chk(host_rvalid && host_rdata == 16'h0, "R8 rvalid/rdata",
                {host_rvalid, host_rdata}, {1'b1, 16'h0});
            @(negedge clk);
            chk(!host_rvalid, "R6 pulse", host_rvalid, 0);
         end
         return;
      end
      n = wr ? WC : RC;
      for (int i = 0; i < n; i++) begin
         if (mem_ce_n || host_ready) ce_err++;
         if (mem_addr != a) addr_err++;
         if (mem_lb_n != !be[0] || mem_ub_n != !be[1]) lane_err++;
         if (wr) begin
            if (mem_we_n != (i >= WLOW) || mem_dq_oe != (i < WLOW) || !mem_oe_n) we_err++;
            if (mem_dq_oe && mem_dq_out != d) we_err++;
         end else begin
            if (mem_oe_n || !mem_we_n || mem_dq_oe) rd_err++;
         end
         if (stray && i >= 2 && (mem_addr != a || mem_ce_n || host_ready)) busy_err++;
         if (stray && i == 1) begin
            host_req = 1'b1; host_write = 1'b1; host_addr = a ^ 18'h3FFC0;
            host_wdata = ~d; host_be = 2'b11;
         end
         if (i == 2) host_req = 1'b0;
         @(negedge clk);
      end
      host_req = 1'b0;
      chk(lane_err == 0, "R2 lanes", lane_err, 0);
      chk(ce_err == 0, "R4 chip select width", ce_err, 0);
      chk(addr_err == 0, "R10 address", addr_err, 0);
      if (stray) chk(busy_err == 0, "R9 ignored while busy", busy_err, 0);
      chk(mem_ce_n && mem_lb_n && mem_ub_n && !mem_dq_oe, "R1 standby after access",
          {mem_ce_n, mem_lb_n, mem_ub_n, mem_dq_oe}, 4'b1110);
      if (wr) begin
         chk(we_err == 0, "R3 write strobe", we_err, 0);
         chk(host_ready, "R4 ready after write", host_ready, 1);
         if (be[0]) shadow[a[5:0]][7:0]  = d[7:0];
         if (be[1]) shadow[a[5:0]][15:8] = d[15:8];
      end else begin
         chk(rd_err == 0, "R5 read strobes", rd_err, 0);
         exp = {be[1] ? shadow[a[5:0]][15:8] : 8'h00, be[0] ? shadow[a[5:0]][7:0] : 8'h00};
         chk(host_rvalid && host_rdata == exp, "R6 read data",
             {host_rvalid, host_rdata}, {1'b1, exp});
         for (int t = 0; t < TURN; t++) begin
            chk(!host_ready, "R7 turnaround", host_ready, 0);
            @(negedge clk);
            chk(!host_rvalid, "R6 pulse", host_rvalid, 0);
         end
         chk(host_ready && mem_ce_n, "R7 ready after turnaround", host_ready, 1);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      for (int i = 0; i < 64; i++) begin model[i] = '0; shadow[i] = '0; end
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1
      chk(host_ready && !host_rvalid && mem_ce_n && mem_we_n && mem_oe_n &&
          mem_lb_n && mem_ub_n && !mem_dq_oe, "R1 reset state",
          {host_ready, host_rvalid, mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe},
          8'b10111110);
      // full-word fill
      for (int i = 0; i < 16; i++)
         access(1'b1, 18'(i) | (18'(i * 2749) << 6), 16'(i * 40503 + 4661), 2'b11, i == 3);
      // partial overwrites, every lane mask including empty
      for (int i = 0; i < 16; i++)
         access(1'b1, 18'(i) | (18'(i * 2749) << 6), 16'(i * 7919 + 12345), 2'(i), 1'b0);
      // read back under every lane mask
      for (int i = 0; i < 16; i++)
         for (int m = 0; m < 4; m++)
            access(1'b0, 18'(i) | (18'(i * 2749) << 6), 16'h0, 2'(m), (i == 5 && m == 3));
      // read immediately followed by write, then read back
      access(1'b0, 18'h3FFC9, 16'h0, 2'b11, 1'b0);
      access(1'b1, 18'h3FFC9, 16'hC3E1, 2'b10, 1'b0);
      access(1'b0, 18'h3FFC9, 16'h0, 2'b11, 1'b0);
      finish_run();
   end

endmodule